// File: doc/BRIEF.md
# Sub-word video integer ALU

This block is a one-stage integer datapath for 32-bit video arithmetic. From each of two source words it picks a byte, a half-word or the whole word. It widens each piece to a 33-bit signed value, using zero or sign extension as requested. It then applies one primary operation and forms a 34-bit signed intermediate. If requested, that intermediate is clamped to the range of the destination type.

A final stage then works with the third operand `c`. It can combine the clamped value with `c` by addition, minimum or maximum. It can also write the low 8 or 16 bits of the clamped value into a chosen field of `c`, with all other bits of `c` kept. The low 32 bits become the result. The result is registered, so it appears one clock after a request is presented with `in_vld` high.

Top module: `subword_vid_alu`

## Requirements
- R1: In the cycle after `rst` is high, `res` is 0 and `res_vld` is 0.
- R2: A request with `in_vld` high shows its result on `res`, with `res_vld` high, after exactly one rising edge. While `in_vld` is low, `res` keeps its value and `res_vld` is 0.
- R3: The field selectors use these codes: 0 to 3 pick byte 0 to 3, where byte 0 is bits 7:0. Code 4 picks bits 15:0 and code 5 picks bits 31:16. Codes 6 and 7 pick the full word.
- R4: Each picked field is zero-extended when its signedness flag (`a_sgn`, `b_sgn`) is 0 and sign-extended when the flag is 1.
- R5: Primary operation codes on `op`: 0 add, 1 subtract (a minus b), 2 absolute difference, 3 minimum, 4 maximum. All five work on the extended values as signed numbers. Codes 6 and 7 behave as add.
- R6: Primary code 5 compares the extended a and b as signed values and gives an intermediate of 1 or 0. The relation codes on `rel` are 0 eq, 1 ne, 2 lt, 3 le, 4 gt and 5 ge; codes 6 and 7 always give 0.
- R7: With `sat` high, the intermediate is clamped before the final stage. When `d_sgn` is 1 the range is -2^31 to 2^31-1; when `d_sgn` is 0 it is 0 to 2^32-1.
- R8: Final-stage codes on `post`: 1 adds `c`, 2 takes the signed minimum with `c`, 3 takes the signed maximum with `c`. For these, `c` is extended according to `d_sgn`, and the stage works on the value after clamping. Codes 0, 6 and 7 pass the value through.
- R9: Final-stage code 4 writes the low byte of the value into byte `pos` of `c`, and code 5 writes the low half-word into half `pos[0]` of `c`. All other bits of `c` are unchanged.
- R10: With `sat` low, the result is the low 32 bits of the unclamped value, so overflows wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| a | input | 32 | First source operand |
| b | input | 32 | Second source operand |
| c | input | 32 | Third operand for the final stage |
| a_sel | input | 3 | Field selector for a |
| b_sel | input | 3 | Field selector for b |
| a_sgn | input | 1 | a field is signed |
| b_sgn | input | 1 | b field is signed |
| d_sgn | input | 1 | Destination is signed |
| op | input | 3 | Primary operation code |
| rel | input | 3 | Compare relation code |
| sat | input | 1 | Clamp enable |
| post | input | 3 | Final-stage code |
| pos | input | 2 | Insert position for the merge codes |
| res | output | 32 | Registered result |
| res_vld | output | 1 | Result valid |

## Verification
Two functions can act on the same request: clamping and the final stage. The bench provokes this with a signed add that overflows, has `sat` set, and is then followed by a final add of `c`. The expected value comes from clamping first and then adding, which checks that the final stage sees the clamped value. A compare whose 0/1 result is merged into a byte of an all-ones `c` checks in the same way that the compare output reaches the merge path. The untouched bytes are compared bit for bit.

// File: rtl/svalu_pkg.sv
package svalu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_ABSD = 3'd2, OP_MIN = 3'd3,
    OP_MAX = 3'd4, OP_CMP = 3'd5, OP_RSV6 = 3'd6, OP_RSV7 = 3'd7
  } prim_op_e;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0, REL_NE = 3'd1, REL_LT = 3'd2, REL_LE = 3'd3,
    REL_GT = 3'd4, REL_GE = 3'd5, REL_RSV6 = 3'd6, REL_RSV7 = 3'd7
  } cmp_rel_e;

  typedef enum logic [2:0] {
    PM_NONE = 3'd0, PM_ADD = 3'd1, PM_MIN = 3'd2, PM_MAX = 3'd3,
    PM_MRGB = 3'd4, PM_MRGH = 3'd5, PM_RSV6 = 3'd6, PM_RSV7 = 3'd7
  } post_mode_e;

  localparam logic [2:0] SEL_H0 = 3'd4;
  localparam logic [2:0] SEL_H1 = 3'd5;
endpackage

// File: rtl/svalu_extract.sv
module svalu_extract #(
  parameter int DW = 32,
  parameter int EW = DW + 1
) (
  input  logic [DW-1:0] opnd,
  input  logic [2:0]    sel,
  input  logic          sgn,
  output logic [EW-1:0] ext
);
  import svalu_pkg::*;

  logic [7:0]  byt;
  logic [15:0] hw;

  always_comb begin
    byt = opnd[{sel[1:0], 3'b000} +: 8];
    hw  = opnd[{sel[0], 4'b0000} +: 16];
    if (sel[2] == 1'b0) begin
      ext = sgn ? {{(EW-8){byt[7]}}, byt} : {{(EW-8){1'b0}}, byt};
    end else if (sel == SEL_H0 || sel == SEL_H1) begin
      ext = sgn ? {{(EW-16){hw[15]}}, hw} : {{(EW-16){1'b0}}, hw};
    end else begin
      ext = {{(EW-DW){sgn & opnd[DW-1]}}, opnd};
    end
  end
endmodule

// File: rtl/svalu_primary.sv
module svalu_primary #(
  parameter int DW = 32,
  parameter int EW = DW + 1,
  parameter int IW = DW + 2
) (
  input  logic [EW-1:0]        ea,
  input  logic [EW-1:0]        eb,
  input  logic [2:0]           op,
  input  logic [2:0]           rel,
  output logic signed [IW-1:0] inter
);
  import svalu_pkg::*;

  logic signed [IW-1:0] sa, sb, df;
  logic                 lt, eq, hit;

  always_comb begin
    sa = {ea[EW-1], ea};
    sb = {eb[EW-1], eb};
    df = sa - sb;
    lt = sa < sb;
    eq = sa == sb;
    case (cmp_rel_e'(rel))
      REL_EQ:  hit = eq;
      REL_NE:  hit = !eq;
      REL_LT:  hit = lt;
      REL_LE:  hit = lt | eq;
      REL_GT:  hit = !(lt | eq);
      REL_GE:  hit = !lt;
      default: hit = 1'b0;
    endcase
    case (prim_op_e'(op))
      OP_SUB:  inter = df;
      OP_ABSD: inter = df[IW-1] ? -df : df;
      OP_MIN:  inter = lt ? sa : sb;
      OP_MAX:  inter = lt ? sb : sa;
      OP_CMP:  inter = {{(IW-1){1'b0}}, hit};
      default: inter = sa + sb;
    endcase
  end
endmodule

// File: rtl/svalu_post.sv
module svalu_post #(
  parameter int DW = 32,
  parameter int IW = DW + 2
) (
  input  logic signed [IW-1:0] inter,
  input  logic [DW-1:0]        c,
  input  logic                 d_sgn,
  input  logic                 sat,
  input  logic [2:0]           post,
  input  logic [1:0]           pos,
  output logic [DW-1:0]        res
);
  import svalu_pkg::*;

  localparam logic signed [IW-1:0] ONE  = 1;
  localparam logic signed [IW-1:0] SMAX = (ONE <<< (DW-1)) - ONE;
  localparam logic signed [IW-1:0] SMIN = -(ONE <<< (DW-1));
  localparam logic signed [IW-1:0] UMAX = (ONE <<< DW) - ONE;

  logic signed [IW-1:0] clp, ce, sum, fin;
  logic                 c_lt;

  always_comb begin
    clp = inter;
    if (sat) begin
      if (d_sgn) begin
        if (inter > SMAX)      clp = SMAX;
        else if (inter < SMIN) clp = SMIN;
      end else begin
        if (inter > UMAX)      clp = UMAX;
        else if (inter < 0)    clp = '0;
      end
    end
    ce   = d_sgn ? {{(IW-DW){c[DW-1]}}, c} : {{(IW-DW){1'b0}}, c};
    sum  = clp + ce;
    c_lt = clp < ce;
    fin  = clp;
    res  = clp[DW-1:0];
    case (post_mode_e'(post))
      PM_ADD:  res = sum[DW-1:0];
      PM_MIN:  begin fin = c_lt ? clp : ce; res = fin[DW-1:0]; end
      PM_MAX:  begin fin = c_lt ? ce : clp; res = fin[DW-1:0]; end
      PM_MRGB: begin res = c; res[{pos, 3'b000} +: 8] = clp[7:0]; end
      PM_MRGH: begin res = c; res[{pos[0], 4'b0000} +: 16] = clp[15:0]; end
      default: res = clp[DW-1:0];
    endcase
  end
endmodule

// File: rtl/subword_vid_alu.sv
module subword_vid_alu #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [31:0]   a,
  input  logic [31:0]   b,
  input  logic [31:0]   c,
  input  logic [2:0]    a_sel,
  input  logic [2:0]    b_sel,
  input  logic          a_sgn,
  input  logic          b_sgn,
  input  logic          d_sgn,
  input  logic [2:0]    op,
  input  logic [2:0]    rel,
  input  logic          sat,
  input  logic [2:0]    post,
  input  logic [1:0]    pos,
  output logic [31:0]   res,
  output logic          res_vld
);
  import svalu_pkg::*;

  localparam int EW = DW + 1;
  localparam int IW = DW + 2;

  logic [EW-1:0]        ext_a, ext_b;
  logic signed [IW-1:0] inter;
  logic [DW-1:0]        res_d, res_q;
  logic                 vld_q;

  svalu_extract #(.DW(DW), .EW(EW)) u_ext_a (
    .opnd(a), .sel(a_sel), .sgn(a_sgn), .ext(ext_a));
  svalu_extract #(.DW(DW), .EW(EW)) u_ext_b (
    .opnd(b), .sel(b_sel), .sgn(b_sgn), .ext(ext_b));

  svalu_primary #(.DW(DW), .EW(EW), .IW(IW)) u_prim (
    .ea(ext_a), .eb(ext_b), .op(op), .rel(rel), .inter(inter));

  svalu_post #(.DW(DW), .IW(IW)) u_post (
    .inter(inter), .c(c), .d_sgn(d_sgn), .sat(sat),
    .post(post), .pos(pos), .res(res_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= res_d;
    end
  end

  assign res     = res_q;
  assign res_vld = vld_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !vld_q));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> vld_q);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(res_q) && !vld_q));

  p_cmp_boolean_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'd5 && post == 3'd0) |=> (res_q[DW-1:1] == '0));

  p_merge_byte_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && post == 3'd4 && pos == 2'd0) |=> (res_q[DW-1:8] == $past(c[DW-1:8])));

  p_merge_half_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && post == 3'd5 && pos[0]) |=> (res_q[15:0] == $past(c[15:0])));
endmodule

// File: tb/subword_vid_alu_bench.sv
module subword_vid_alu_bench;
  typedef struct packed {
    logic [31:0] a, b, c;
    logic [2:0]  asel, bsel;
    logic        asgn, bsgn, dsgn;
    logic [2:0]  op, rel;
    logic        sat;
    logic [2:0]  post;
    logic [1:0]  pos;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  // fields: a, b, c, asel, bsel, asgn, bsgn, dsgn, op, rel, sat, post, pos, exp, requirement
  localparam vec_t TBL [NV] = '{
    '{32'hF0, 32'h20, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h110, 4'd3},      // R3 byte0
    '{32'h7F000000, 32'h0, 32'h0, 3'd3, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h7F, 4'd3}, // R3 byte3
    '{32'hF0, 32'h20, 32'h0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h10, 4'd4},      // R4 sign ext
    '{32'h12340000, 32'h34, 32'h0, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 3'd0, 2'd0, 32'h1200, 4'd5}, // R5 sub, h1
    '{32'h5, 32'h900, 32'h0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 3'd0, 2'd0, 32'h4, 4'd5},       // R5 absd
    '{32'h3, 32'h900, 32'h0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0, 3'd0, 2'd0, 32'h6, 4'd5},       // R5 absd neg
    '{32'hFF00, 32'h3, 32'h0, 3'd1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd3, 3'd0, 1'b0, 3'd0, 2'd0, 32'hFFFFFFFF, 4'd5}, // R5 min
    '{32'hFF00, 32'h3, 32'h0, 3'd1, 3'd0, 1'b1, 1'b0, 1'b1, 3'd4, 3'd0, 1'b0, 3'd0, 2'd0, 32'h3, 4'd5},      // R5 max
    '{32'h3, 32'h4, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd7, 3'd0, 1'b0, 3'd0, 2'd0, 32'h7, 4'd5},         // R5 code 7
    '{32'h80, 32'h10, 32'h0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 3'd2, 1'b0, 3'd0, 2'd0, 32'h1, 4'd6},       // R6 lt
    '{32'h80, 32'h10, 32'h0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd5, 3'd5, 1'b0, 3'd0, 2'd0, 32'h0, 4'd6},       // R6 ge
    '{32'h00AB0000, 32'hAB00, 32'h0, 3'd2, 3'd1, 1'b0, 1'b0, 1'b0, 3'd5, 3'd0, 1'b0, 3'd0, 2'd0, 32'h1, 4'd6}, // R6 eq
    '{32'h00AB0000, 32'hAB00, 32'h0, 3'd2, 3'd1, 1'b0, 1'b0, 1'b0, 3'd5, 3'd1, 1'b0, 3'd0, 2'd0, 32'h0, 4'd6}, // R6 ne
    '{32'h5, 32'h5, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, 3'd3, 1'b0, 3'd0, 2'd0, 32'h1, 4'd6},         // R6 le
    '{32'h5, 32'h5, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, 3'd4, 1'b0, 3'd0, 2'd0, 32'h0, 4'd6},         // R6 gt
    '{32'h5, 32'h5, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, 3'd6, 1'b0, 3'd0, 2'd0, 32'h0, 4'd6},         // R6 rsv rel
    '{32'h7FFFFFFF, 32'h1, 32'h0, 3'd6, 3'd6, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b1, 3'd0, 2'd0, 32'h7FFFFFFF, 4'd7}, // R7 smax
    '{32'h80000000, 32'h1, 32'h0, 3'd7, 3'd6, 1'b1, 1'b1, 1'b1, 3'd1, 3'd0, 1'b1, 3'd0, 2'd0, 32'h80000000, 4'd7}, // R7 smin
    '{32'h0, 32'h1, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b1, 3'd0, 2'd0, 32'h0, 4'd7},         // R7 umin
    '{32'hFFFFFFFF, 32'h1, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 2'd0, 32'hFFFFFFFF, 4'd7}, // R7 umax
    '{32'h7FFFFFFF, 32'h1, 32'h0, 3'd6, 3'd6, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 3'd0, 2'd0, 32'h80000000, 4'd10}, // R10 wrap
    '{32'h0, 32'h1, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 3'd0, 2'd0, 32'hFFFFFFFF, 4'd10},  // R10 wrap
    '{32'h3, 32'h4, 32'h100, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd1, 2'd0, 32'h107, 4'd8},     // R8 add c
    '{32'h2, 32'h5, 32'h10, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 3'd2, 2'd0, 32'hFFFFFFFD, 4'd8}, // R8 min c
    '{32'h2, 32'h5, 32'h10, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 3'd3, 2'd0, 32'h10, 4'd8},       // R8 max c
    '{32'h7FFFFFFF, 32'h1, 32'h1, 3'd6, 3'd6, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b1, 3'd1, 2'd0, 32'h80000000, 4'd8}, // R8 sat then add
    '{32'h12, 32'h34, 32'hAABBCCDD, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd4, 2'd2, 32'hAA46CCDD, 4'd9}, // R9 byte2
    '{32'h1234, 32'h1, 32'hAABBCCDD, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd5, 2'd1, 32'h1235CCDD, 4'd9}, // R9 half1
    '{32'hFFFF, 32'h1, 32'hAABBCCDD, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd5, 2'd0, 32'hAABB0000, 4'd9}, // R9 half0 trunc
    '{32'h5, 32'h5, 32'hFFFFFFFF, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd5, 3'd0, 1'b0, 3'd4, 2'd0, 32'hFFFFFF01, 4'd9}  // R9 cmp merge
  };

  logic clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [2:0]  a_sel = '0, b_sel = '0, op = '0, rel = '0, post = '0;
  logic        a_sgn = 1'b0, b_sgn = 1'b0, d_sgn = 1'b0, sat = 1'b0;
  logic [1:0]  pos = '0;
  logic [31:0] res;
  logic        res_vld;
  int          n_chk = 0, n_err = 0;
  logic [31:0] held;

  always #2 clk = ~clk;

  subword_vid_alu u_subword_vid_alu (
    .clk(clk), .rst(rst), .in_vld(in_vld), .a(a), .b(b), .c(c),
    .a_sel(a_sel), .b_sel(b_sel), .a_sgn(a_sgn), .b_sgn(b_sgn), .d_sgn(d_sgn),
    .op(op), .rel(rel), .sat(sat), .post(post), .pos(pos),
    .res(res), .res_vld(res_vld));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin : watchdog
    #400000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", res, 32'h0);
    check("R1", {31'b0, res_vld}, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {a, b, c} = {TBL[i].a, TBL[i].b, TBL[i].c};
      a_sel = TBL[i].asel; b_sel = TBL[i].bsel;
      a_sgn = TBL[i].asgn; b_sgn = TBL[i].bsgn; d_sgn = TBL[i].dsgn;
      op = TBL[i].op; rel = TBL[i].rel; sat = TBL[i].sat;
      post = TBL[i].post; pos = TBL[i].pos; in_vld = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", TBL[i].rq, i), res, TBL[i].exp);
      check("R2 valid", {31'b0, res_vld}, 32'h1);
      in_vld = 1'b0;
    end
    // R2: idle request with new operands must leave res unchanged
    held = res;
    a = 32'h55; b = 32'h66; op = 3'd0; post = 3'd0;
    @(negedge clk);
    check("R2 hold", res, held);
    check("R2 idle valid", {31'b0, res_vld}, 32'h0);
    // R1: reset after activity clears outputs
    rst = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    check("R1 reclear", res, 32'h0);
    check("R1 reclear valid", {31'b0, res_vld}, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule